// File: doc/BRIEF.md
# Multi-Master SCL Clock Generator

This block produces the serial clock of an I2C master on an open-drain, wired-AND line and keeps that clock aligned with any other master driving the same line. It never drives the line high. It either requests a low drive or lets the line go, and it times both phases from edges it sees on the shared line, not from its own output. Two counts, given in system clock cycles, set the length of the low phase and the high phase.

When the synchronization enable is set, a falling edge caused by another master during the high phase cuts that phase short. The block then drives low at once and starts its own low count. When its low count ends, the block releases the line. It does not start the next high count until the line has actually risen. As a result, the shared clock takes the shortest high phase and the longest low phase among the contending masters. The sampled line input is expected to be synchronized and filtered already. Start and stop conditions, data shifting and arbitration belong to surrounding logic.

Top module: `scl_clock_gen`

## Requirements
- R1: While reset is active or `run` is 0, `scl_drive_low` is 0. Taking `run` to 0 in any phase releases the line on the following cycle.
- R2: Each low phase drives `scl_drive_low` to 1 for exactly `low_cnt` consecutive cycles, also when another master keeps the line low for longer.
- R3: After the block releases the line, it stays released through the cycle in which the line's rise is detected and then for `high_cnt` more cycles. In an uncontended period the released time is therefore `high_cnt`+1 cycles.
- R4: When the high count completes, `scl_drive_low` goes to 1 on the next cycle without any external stimulus.
- R5: With `sync_en`=1, a falling line level seen during the high phase sets `scl_drive_low` to 1 on the next cycle, and a full low count of `low_cnt` cycles starts from there.
- R6: With `sync_en`=0, a falling line level during the high phase has no effect. The released time stays `high_cnt`+1 cycles.
- R7: While the line is held low by another master after the block has released it, `scl_drive_low` stays 0 and no high count runs until the line rises.
- R8: `rise_pulse` is 1 for exactly the cycle in which `scl_in` is 1 and was 0 in the previous cycle. `fall_pulse` behaves the same way for a 1-to-0 change. Both are 0 after reset while the line is high.
- R9: When `run` goes to 1 with the line high, the high count starts on the next cycle. `scl_drive_low` goes to 1 after `high_cnt`+1 released cycles, counting the cycle in which `run` was first 1.
- R10: A programmed count of 0 behaves as a count of 1 for both phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Enables clock generation; 0 forces idle |
| sync_en | input | 1 | Allows an external falling edge to abort the high phase |
| high_cnt | input | W | High phase length in clock cycles |
| low_cnt | input | W | Low phase length in clock cycles |
| scl_in | input | 1 | Synchronized level of the shared SCL line |
| scl_drive_low | output | 1 | Request to pull the line low (open-drain enable) |
| rise_pulse | output | 1 | One-cycle pulse on a detected rising edge |
| fall_pulse | output | 1 | One-cycle pulse on a detected falling edge |

## Verification
The hardest situations to reach are the two contention cases. In one, another master pulls the line low partway through the high count. In the other, another master keeps the line low after this block has released it. The bench models the wired-AND line as the inverse of the OR of the block's request and a second "foreign master" request. It places that foreign request at a chosen negedge relative to the block's own release, with sync enabled and with sync disabled. It then measures the phase lengths that follow, cycle by cycle.

// File: rtl/scl_clock_gen.sv
module scl_clock_gen #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         sync_en,
  input  logic [W-1:0] high_cnt,
  input  logic [W-1:0] low_cnt,
  input  logic         scl_in,
  output logic         scl_drive_low,
  output logic         rise_pulse,
  output logic         fall_pulse
);
  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HIGH, S_LOW} st_t;

  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  st_t          st;
  logic [W-1:0] cnt;
  logic         scl_q;
  logic         hi_phase;
  logic [W-1:0] hi_last, lo_last;

  assign hi_last    = (high_cnt == '0) ? '0 : high_cnt - ONE;
  assign lo_last    = (low_cnt  == '0) ? '0 : low_cnt  - ONE;
  assign rise_pulse = scl_in & ~scl_q;
  assign fall_pulse = ~scl_in & scl_q;
  assign hi_phase   = (st == S_HIGH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st            <= S_IDLE;
      cnt           <= '0;
      scl_drive_low <= 1'b0;
      scl_q         <= 1'b1;
    end else begin
      scl_q <= scl_in;
      if (!run) begin
        st            <= S_IDLE;
        cnt           <= '0;
        scl_drive_low <= 1'b0;
      end else begin
        case (st)
          S_IDLE: begin
            cnt <= '0;
            st  <= scl_in ? S_HIGH : S_WAIT;
          end
          S_WAIT: begin
            if (rise_pulse) begin
              st  <= S_HIGH;
              cnt <= '0;
            end
          end
          S_HIGH: begin
            if ((sync_en && fall_pulse) || cnt == hi_last) begin
              st            <= S_LOW;
              cnt           <= '0;
              scl_drive_low <= 1'b1;
            end else begin
              cnt <= cnt + ONE;
            end
          end
          S_LOW: begin
            if (cnt == lo_last) begin
              st            <= S_WAIT;
              cnt           <= '0;
              scl_drive_low <= 1'b0;
            end else begin
              cnt <= cnt + ONE;
            end
          end
        endcase
      end
    end
  end
endmodule

module scl_clock_gen_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         sync_en,
  input logic [W-1:0] low_cnt,
  input logic         scl_in,
  input logic         scl_drive_low,
  input logic         rise_pulse,
  input logic         fall_pulse,
  input logic         hi_phase
);
  logic [W:0] drive_len;
  logic [W:0] lo_eff;

  assign lo_eff = (low_cnt == '0) ? {{W{1'b0}}, 1'b1} : {1'b0, low_cnt};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drive_len <= '0;
    else        drive_len <= scl_drive_low ? drive_len + 1'b1 : '0;
  end

  // R1
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !scl_drive_low);

  // R1
  drive_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_drive_low) |-> $past(run));

  // R2
  low_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_drive_low |-> drive_len < lo_eff);

  // R5
  sync_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && sync_en && hi_phase && fall_pulse |=> scl_drive_low);

  // R7
  stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run && !scl_drive_low && !scl_in && !hi_phase |=> !scl_drive_low);

  // R8
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_pulse |=> !rise_pulse);

  // R8
  fall_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fall_pulse |=> !fall_pulse);
endmodule

bind scl_clock_gen scl_clock_gen_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .sync_en(sync_en), .low_cnt(low_cnt),
  .scl_in(scl_in), .scl_drive_low(scl_drive_low), .rise_pulse(rise_pulse),
  .fall_pulse(fall_pulse), .hi_phase(hi_phase)
);

// File: tb/scl_clock_gen_tb.sv
module scl_clock_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;
  localparam int NV = 6;
  // {sync_en, high_cnt, low_cnt}
  localparam logic [2*W:0] VEC [NV] = '{
    {1'b0, 16'd3,  16'd2},
    {1'b1, 16'd5,  16'd7},
    {1'b0, 16'd1,  16'd1},
    {1'b1, 16'd10, 16'd4},
    {1'b1, 16'd2,  16'd9},
    {1'b0, 16'd16, 16'd3}
  };

  logic clk = 0, rst_n = 0, run = 0, sync_en = 0, ext_low = 0;
  logic [W-1:0] high_cnt = 0, low_cnt = 0;
  logic scl_line, drv, rise, fall;
  int n_chk = 0, n_fail = 0;

  assign scl_line = ~(drv | ext_low);

  scl_clock_gen #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .sync_en(sync_en),
    .high_cnt(high_cnt), .low_cnt(low_cnt), .scl_in(scl_line),
    .scl_drive_low(drv), .rise_pulse(rise), .fall_pulse(fall)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string r, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  task automatic cnt_rel(output int n);
    n = 0;
    while (!drv && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic cnt_low(output int n);
    n = 0;
    while (drv && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic start(input logic s, input int h, input int l);
    run = 0; sync_en = s; high_cnt = W'(h); low_cnt = W'(l);
    @(negedge clk); @(negedge clk);
    run = 1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a, b, h, l, bad;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset drive", drv, 0);
    chk("R8 reset rise", rise, 0);
    chk("R8 reset fall", fall, 0);
    rst_n = 1;
    @(negedge clk);

    // R8 edge pulses
    ext_low = 1; #1;
    chk("R8 fall pulse", fall, 1);
    chk("R8 no rise on fall", rise, 0);
    @(negedge clk); #1;
    chk("R8 fall one cycle", fall, 0);
    ext_low = 0; #1;
    chk("R8 rise pulse", rise, 1);
    @(negedge clk); #1;
    chk("R8 rise one cycle", rise, 0);
    @(negedge clk);

    // Vector table: R9 first high, R2 low length, R3/R4 period
    for (int i = 0; i < NV; i++) begin
      h = int'(VEC[i][2*W-1:W]); l = int'(VEC[i][W-1:0]);
      start(VEC[i][2*W], h, l);
      cnt_rel(a); chk("R9 first high", a, h + 1);
      cnt_low(a); chk("R2 low length", a, l);
      cnt_rel(a); chk("R3 R4 released length", a, h + 1);
      cnt_low(a); chk("R2 low length again", a, l);
    end

    // R5 sync abort
    start(1'b1, 20, 5);
    cnt_rel(a); cnt_low(a);
    repeat (4) @(negedge clk);
    ext_low = 1;
    @(negedge clk);
    chk("R5 abort drives low", drv, 1);
    ext_low = 0;
    cnt_low(a); chk("R5 low after abort", a, 5);
    cnt_rel(a); chk("R5 next high normal", a, 21);

    // R6 sync disabled, falling edge ignored
    start(1'b0, 20, 5);
    cnt_rel(a); cnt_low(a);
    a = 0;
    repeat (4) begin if (!drv) a++; @(negedge clk); end
    ext_low = 1;
    if (!drv) a++;
    @(negedge clk);
    chk("R6 no abort", drv, 0);
    ext_low = 0;
    cnt_rel(b); chk("R6 high unchanged", a + b, 21);

    // R7 low stretched by other master
    start(1'b1, 6, 4);
    cnt_rel(a);
    ext_low = 1;
    cnt_low(a); chk("R2 low under stretch", a, 4);
    bad = 0;
    repeat (12) begin if (drv) bad++; @(negedge clk); end
    chk("R7 held released while line low", bad, 0);
    ext_low = 0;
    cnt_rel(a); chk("R7 R3 high after stretch", a, 7);

    // R10 zero counts
    start(1'b0, 0, 0);
    cnt_rel(a); chk("R10 first high zero", a, 2);
    cnt_low(a); chk("R10 low zero", a, 1);
    cnt_rel(a); chk("R10 high zero", a, 2);

    // R1 run dropped during low phase
    start(1'b0, 4, 30);
    cnt_rel(a);
    repeat (3) @(negedge clk);
    run = 0;
    @(negedge clk);
    chk("R1 run off releases", drv, 0);
    bad = 0;
    repeat (8) begin if (drv) bad++; @(negedge clk); end
    chk("R1 stays idle", bad, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule